// File: doc/BRIEF.md
# Raster Timing Generator with Colour-Bar Pattern

This block produces the raster timing for a flat-panel pixel interface. A simple word-addressed register bus sets the active width and height, the front porch, sync pulse and back porch of both axes, the polarity of each sync output, an operating mode and a bank of eight colour-bar entries. From these the block drives horizontal sync, vertical sync, composite sync, a data-enable strobe, 24-bit RGB pixel data and the current pixel column and row.

In pass-through mode the RGB output carries an external pixel stream whenever data-enable is high. In bar mode the active line is cut into eight vertical stripes, each filled with its programmed colour, which gives a test image without any memory traffic. Three timing events (start of vertical blanking, frame end and a programmable line match) set sticky status bits. Each bit can be masked, and the unmasked bits drive a single interrupt line.

Geometry writes land in live registers and reach the counters only at a frame boundary. Software therefore stops the output, reprograms the geometry and restarts it, or lets a running display change cleanly at the next frame.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the mode is off, data-enable, the sync outputs, RGB, column, row and the interrupt are all 0, and the interrupt mask (address 6) reads 0x3F.
- R2: Each line runs active pixels, then front porch, then sync pulse, then back porch. Frames do the same in whole lines. The column and row outputs count from 0 at the first active pixel or line and advance by one per clock or per line.
- R3: Register layout: address 1 (horizontal) and address 2 (vertical) hold back porch in [31:22], pulse width in [21:11] and front porch in [10:0]. Address 3 holds active height in [26:16] and active width in [10:0]. All of them read back as written.
- R4: Data-enable is high only when the column is below the active width and the row is below the active height.
- R5: Address 4 bit 0 inverts horizontal sync, bit 1 inverts vertical sync and bit 2 inverts composite sync. Composite sync is the XOR of the uninverted horizontal and vertical syncs, and its own inversion is applied after the XOR.
- R6: The mode field is address 0 bits [2:0]. Value 1 passes the pixel input to RGB during data-enable. Value 4 selects colour bars. Values 0, 2 and 3 are off: data-enable, RGB, column and row stay 0 and the syncs sit at their inactive levels.
- R7: In bar mode, bar k (k = 0 at the left, address 8+k, red [23:16], green [15:8], blue [7:0]) covers columns from k*(W/8) up to the next bar. The division is an integer division, and bar 7 also takes the remainder. When W is below 8, every pixel shows bar 7.
- R8: Writing a nonzero mode restarts the raster at column 0, row 0 in the next cycle, even while the display is running.
- R9: Geometry writes made while the display is running take effect only when the row counter wraps at the end of the frame.
- R10: Status (address 5) bit 0 is set at the end of the last active line, bit 1 at the end of the frame and bit 2 at the end of the line whose row equals address 7. Bits [5:3] read 0. Writing ones clears the matching bits, and a new event in the same cycle wins over the clear.
- R11: The interrupt is high when any status bit is set whose mask bit (address 6) is 0. A mask of 0x3F holds the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pix_in | input | 3*CDW (24) | External pixel data used in pass-through mode |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| csync | output | 1 | Composite sync after polarity |
| de | output | 1 | Data-enable |
| rgb | output | 3*CDW (24) | Pixel data, red in the top byte |
| pix_x | output | CW (13) | Current column |
| pix_y | output | CW (13) | Current row |
| irq | output | 1 | OR of unmasked status bits |

## Verification
The bench uses a small raster (16x4 active, short porches) so that every pixel of several whole frames is compared against a position model that the bench computes from its own cycle count. It runs that sweep under pass-through data, bar mode with a width divisible by eight, a width of 20 that leaves a remainder for the last bar and a width of 5 that collapses every pixel into bar 7, which separates the bar-boundary arithmetic from the simple shift case. Further sweeps run with every polarity bit set and with only the vertical bit set, with mode values 2 and 3, with restarts issued mid-frame, and with geometry rewritten mid-frame, so that early and late latching of the new timing give different outputs. Interrupt masks of all ones, all zeros and a partial pattern are applied while the status bits are cleared by write-back and set again by new events.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
   localparam int FW      = 11;   // width of width/height/front/pulse fields
   localparam int BPW     = 10;   // width of back porch field
   localparam int NSRC    = 3;    // implemented interrupt sources
   localparam int STW     = 6;    // architectural status/mask width
   localparam int HBP_LSB = 22;
   localparam int PW_LSB  = 11;
   localparam int FP_LSB  = 0;
   localparam int SZH_LSB = 16;

   localparam int A_CTRL = 0;
   localparam int A_HTIM = 1;
   localparam int A_VTIM = 2;
   localparam int A_SIZE = 3;
   localparam int A_POL  = 4;
   localparam int A_STAT = 5;
   localparam int A_MASK = 6;
   localparam int A_LCMP = 7;
   localparam int A_BAR0 = 8;

   localparam logic [2:0] MODE_PIX = 3'd1;
   localparam logic [2:0] MODE_BAR = 3'd4;

   typedef struct packed {
      logic [FW-1:0]  act;
      logic [FW-1:0]  fp;
      logic [FW-1:0]  pw;
      logic [BPW-1:0] bp;
   } axis_t;

   typedef struct packed {
      axis_t h;
      axis_t v;
   } geom_t;
endpackage

// File: rtl/rtg_axis.sv
`timescale 1ns/1ps
module rtg_axis
   import rtg_pkg::*;
#(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          en,
   input  axis_t         cfg,
   output logic [CW-1:0] cnt,
   output logic          last,
   output logic          act,
   output logic          sync
);
   logic [CW-1:0] sync_lo, sync_hi, total;

   assign sync_lo = CW'(cfg.act) + CW'(cfg.fp);
   assign sync_hi = sync_lo + CW'(cfg.pw);
   assign total   = sync_hi + CW'(cfg.bp);

   assign last = (cnt + CW'(1)) >= total;
   assign act  = cnt < CW'(cfg.act);
   assign sync = (cnt >= sync_lo) && (cnt < sync_hi);

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (en)
         cnt <= last ? '0 : cnt + CW'(1);
   end
endmodule

// File: rtl/rtg_bars.sv
`timescale 1ns/1ps
module rtg_bars
   import rtg_pkg::*;
#(
   parameter int CW    = 13,
   parameter int NBARS = 8,
   parameter int CDW   = 8
) (
   input  logic [CW-1:0]                    x,
   input  logic [FW-1:0]                    width,
   input  logic [NBARS-1:0][3*CDW-1:0]      bars,
   output logic [3*CDW-1:0]                 colour
);
   localparam int BSH = $clog2(NBARS);
   localparam int IW  = $clog2(NBARS);

   logic [FW-1:0]      bw;
   logic [NBARS-1:1]   passed;
   logic [IW-1:0]      idx;

   assign bw = width >> BSH;

   for (genvar k = 1; k < NBARS; k++) begin : g_edge
      assign passed[k] = x >= (CW'(k) * CW'(bw));
   end

   always_comb begin
      idx = '0;
      for (int k = 1; k < NBARS; k++)
         idx = idx + IW'(passed[k]);
   end

   assign colour = bars[idx];
endmodule

// File: rtl/rtg_regs.sv
`timescale 1ns/1ps
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int NBARS = 8,
   parameter int CDW   = 8,
   parameter int AW    = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr,
   input  logic [AW-1:0]                 addr,
   input  logic [31:0]                   wdata,
   output logic [31:0]                   rdata,
   input  logic [NSRC-1:0]               ev,
   output logic [2:0]                    mode,
   output logic                          restart,
   output geom_t                         geom,
   output logic [2:0]                    pol,
   output logic [STW-1:0]                mask,
   output logic [FW-1:0]                 lcmp,
   output logic [NBARS-1:0][3*CDW-1:0]   bars,
   output logic                          irq
);
   localparam int PXW = 3 * CDW;
   localparam int IW  = $clog2(NBARS);

   logic [NSRC-1:0] stat;
   logic [NSRC-1:0] clr_bits;

   assign restart  = wr && (addr == AW'(A_CTRL)) && (wdata[2:0] != 3'd0);
   assign clr_bits = (wr && (addr == AW'(A_STAT))) ? wdata[NSRC-1:0] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= '0;
         geom <= '0;
         pol  <= '0;
         mask <= '1;
         lcmp <= '0;
         stat <= '0;
         bars <= '0;
      end else begin
         stat <= (stat & ~clr_bits) | ev;
         if (wr) begin
            case (addr)
               AW'(A_CTRL): mode <= wdata[2:0];
               AW'(A_HTIM): begin
                  geom.h.bp <= wdata[HBP_LSB +: BPW];
                  geom.h.pw <= wdata[PW_LSB +: FW];
                  geom.h.fp <= wdata[FP_LSB +: FW];
               end
               AW'(A_VTIM): begin
                  geom.v.bp <= wdata[HBP_LSB +: BPW];
                  geom.v.pw <= wdata[PW_LSB +: FW];
                  geom.v.fp <= wdata[FP_LSB +: FW];
               end
               AW'(A_SIZE): begin
                  geom.v.act <= wdata[SZH_LSB +: FW];
                  geom.h.act <= wdata[FW-1:0];
               end
               AW'(A_POL):  pol  <= wdata[2:0];
               AW'(A_MASK): mask <= wdata[STW-1:0];
               AW'(A_LCMP): lcmp <= wdata[FW-1:0];
               default: ;
            endcase
            for (int i = 0; i < NBARS; i++)
               if (addr == AW'(A_BAR0 + i))
                  bars[i] <= wdata[PXW-1:0];
         end
      end
   end

   always_comb begin
      case (addr)
         AW'(A_CTRL): rdata = {29'd0, mode};
         AW'(A_HTIM): rdata = {geom.h.bp, geom.h.pw, geom.h.fp};
         AW'(A_VTIM): rdata = {geom.v.bp, geom.v.pw, geom.v.fp};
         AW'(A_SIZE): rdata = {5'd0, geom.v.act, 5'd0, geom.h.act};
         AW'(A_POL):  rdata = {29'd0, pol};
         AW'(A_STAT): rdata = {{(32-NSRC){1'b0}}, stat};
         AW'(A_MASK): rdata = {{(32-STW){1'b0}}, mask};
         AW'(A_LCMP): rdata = {{(32-FW){1'b0}}, lcmp};
         default:
            if (addr >= AW'(A_BAR0))
               rdata = {{(32-PXW){1'b0}}, bars[IW'(addr - AW'(A_BAR0))]};
            else
               rdata = '0;
      endcase
   end

   assign irq = |(stat & ~mask[NSRC-1:0]);
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int CW    = 13,
   parameter int NBARS = 8,
   parameter int CDW   = 8,
   parameter int AW    = $clog2(A_BAR0 + NBARS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                reg_wr,
   input  logic [AW-1:0]       reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [3*CDW-1:0]    pix_in,
   output logic                hsync,
   output logic                vsync,
   output logic                csync,
   output logic                de,
   output logic [3*CDW-1:0]    rgb,
   output logic [CW-1:0]       pix_x,
   output logic [CW-1:0]       pix_y,
   output logic                irq
);
   localparam int PXW = 3 * CDW;

   if (CW < FW + 2) begin : g_cw_bad
      $error("CW must hold the sum of all timing fields");
   end
   if (NBARS < 2 || (NBARS & (NBARS - 1)) != 0) begin : g_nbars_bad
      $error("NBARS must be a power of two of at least 2");
   end
   if (CDW < 1 || CDW > 8) begin : g_cdw_bad
      $error("CDW must be 1..8");
   end
   if (AW < $clog2(A_BAR0 + NBARS)) begin : g_aw_bad
      $error("AW too narrow for the register map");
   end

   logic [2:0]                 mode, pol;
   logic                       restart, run;
   logic [STW-1:0]             irq_mask;
   logic [FW-1:0]              lcmp;
   geom_t                      live, sh;
   logic [NBARS-1:0][PXW-1:0]  bars;
   logic [NSRC-1:0]            ev;
   logic [CW-1:0]              h_cnt, v_cnt;
   logic                       h_last, h_act, h_sync;
   logic                       v_last, v_act, v_sync;
   logic                       frame_wrap, hs_raw, vs_raw;
   logic [PXW-1:0]             bar_rgb;

   rtg_regs #(.NBARS(NBARS), .CDW(CDW), .AW(AW)) u_regs (
      .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .ev(ev), .mode(mode), .restart(restart), .geom(live),
      .pol(pol), .mask(irq_mask), .lcmp(lcmp), .bars(bars), .irq(irq)
   );

   assign run = (mode == MODE_PIX) || (mode == MODE_BAR);

   rtg_axis #(.CW(CW)) u_hor (
      .clk(clk), .rst(rst), .clr(restart || !run), .en(run), .cfg(sh.h),
      .cnt(h_cnt), .last(h_last), .act(h_act), .sync(h_sync)
   );

   rtg_axis #(.CW(CW)) u_ver (
      .clk(clk), .rst(rst), .clr(restart || !run), .en(run && h_last), .cfg(sh.v),
      .cnt(v_cnt), .last(v_last), .act(v_act), .sync(v_sync)
   );

   assign frame_wrap = run && h_last && v_last;

   // geometry shadow: follows live while stopped, reloads on restart or frame wrap
   always_ff @(posedge clk) begin
      if (rst)
         sh <= '0;
      else if (!run || restart || frame_wrap)
         sh <= live;
   end

   assign ev[0] = run && h_last && ((v_cnt + CW'(1)) == CW'(sh.v.act));
   assign ev[1] = frame_wrap;
   assign ev[2] = run && h_last && (v_cnt == CW'(lcmp));

   rtg_bars #(.CW(CW), .NBARS(NBARS), .CDW(CDW)) u_bars (
      .x(h_cnt), .width(sh.h.act), .bars(bars), .colour(bar_rgb)
   );

   assign hs_raw = run && h_sync;
   assign vs_raw = run && v_sync;
   assign hsync  = hs_raw ^ pol[0];
   assign vsync  = vs_raw ^ pol[1];
   assign csync  = (hs_raw ^ vs_raw) ^ pol[2];
   assign de     = run && h_act && v_act;
   assign rgb    = !de ? '0 : ((mode == MODE_BAR) ? bar_rgb : pix_in);
   assign pix_x  = run ? h_cnt : '0;
   assign pix_y  = run ? v_cnt : '0;
endmodule

// File: rtl/rtg_checker.sv
`timescale 1ns/1ps
module rtg_checker #(
   parameter int CW  = 13,
   parameter int PXW = 24
) (
   input logic           clk,
   input logic           rst,
   input logic           run,
   input logic           restart,
   input logic           h_last,
   input logic [2:0]     pol,
   input logic [5:0]     irq_mask,
   input logic           de,
   input logic           hsync,
   input logic           vsync,
   input logic           csync,
   input logic           irq,
   input logic [PXW-1:0] rgb,
   input logic [CW-1:0]  pix_x,
   input logic [CW-1:0]  pix_y
);
   // R5
   csync_relation_chk: assert property (@(posedge clk) disable iff (rst)
      csync == (hsync ^ vsync ^ pol[0] ^ pol[1] ^ pol[2]));

   // R6
   off_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !run |-> (!de && rgb == '0 && pix_x == '0 && pix_y == '0));

   // R8
   restart_origin_chk: assert property (@(posedge clk) disable iff (rst)
      restart |=> (pix_x == '0 && pix_y == '0));

   // R11
   mask_all_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_mask == 6'h3F) |-> !irq);

   // R2
   column_step_chk: assert property (@(posedge clk) disable iff (rst)
      (run && !restart && !h_last) |=> (!run || pix_x == CW'($past(pix_x) + CW'(1))));

   // R2
   column_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (run && h_last) |=> (pix_x == '0));
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW), .PXW(3*CDW)) u_chk (
   .clk(clk), .rst(rst), .run(run), .restart(restart), .h_last(h_last),
   .pol(pol), .irq_mask(irq_mask), .de(de), .hsync(hsync), .vsync(vsync),
   .csync(csync), .irq(irq), .rgb(rgb), .pix_x(pix_x), .pix_y(pix_y)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
   localparam int CW = 13, AW = 4;

   logic        clk = 1'b0, rst = 1'b1, reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [23:0] pix_in = 24'h123456, rgb;
   logic        hsync, vsync, csync, de, irq;
   logic [CW-1:0] pix_x, pix_y;

   always #4 clk = ~clk;   // 125 MHz

   raster_timing_gen #(.CW(CW)) u_raster_timing_gen (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in(pix_in),
      .hsync(hsync), .vsync(vsync), .csync(csync), .de(de), .rgb(rgb),
      .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
   );

   int errors = 0, checks = 0;
   string req = "R1";

   // bench model; index 0 W,1 H,2 hfp,3 hpw,4 hbp,5 vfp,6 vpw,7 vbp
   int live[8], cur[8], bar_c[8];
   int m_mode = 0, m_pol = 0, m_mask = 63, m_stat = 0, m_lc = 0, bh = 0, bv = 0;

   task automatic check(string r, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (x=%0d y=%0d)", r, what, act, exp, bh, bv);
      end
   endtask

   function automatic int bar_of(int h, int w);
      int bw = w / 8;
      if (bw == 0) return 7;
      return (h / bw > 7) ? 7 : h / bw;
   endfunction

   task automatic check_outputs();
      int w = cur[0], hgt = cur[1];
      bit run = (m_mode == 1) || (m_mode == 4);
      int e_de = 0, e_hr = 0, e_vr = 0, e_rgb = 0, e_x = 0, e_y = 0;
      if (run) begin
         e_de = (bh < w && bv < hgt) ? 1 : 0;
         e_hr = (bh >= w + cur[2] && bh < w + cur[2] + cur[3]) ? 1 : 0;
         e_vr = (bv >= hgt + cur[5] && bv < hgt + cur[5] + cur[6]) ? 1 : 0;
         e_x = bh; e_y = bv;
         if (e_de != 0) e_rgb = (m_mode == 4) ? bar_c[bar_of(bh, w)] : int'(pix_in);
      end
      check(req, "de R4", int'(de), e_de);
      check(req, "hsync R2", int'(hsync), e_hr ^ (m_pol & 1));
      check(req, "vsync R2", int'(vsync), e_vr ^ ((m_pol >> 1) & 1));
      check(req, "csync R5", int'(csync), e_hr ^ e_vr ^ ((m_pol >> 2) & 1));
      check(req, "rgb R6", int'(rgb), e_rgb);
      check(req, "pix_x R2", int'(pix_x), e_x);
      check(req, "pix_y R2", int'(pix_y), e_y);
      check(req, "irq R11", int'(irq), ((m_stat & ~m_mask & 7) != 0) ? 1 : 0);
   endtask

   task automatic model_edge(bit w, int a, int d);
      bit run = (m_mode == 1) || (m_mode == 4);
      int ht = cur[0] + cur[2] + cur[3] + cur[4];
      int vt = cur[1] + cur[5] + cur[6] + cur[7];
      bit hl = (bh + 1 >= ht);
      bit vl = (bv + 1 >= vt);
      int set = 0, clr = 0;
      if (run && hl) begin
         if (bv + 1 == cur[1]) set |= 1;
         if (vl) set |= 2;
         if (bv == m_lc) set |= 4;
      end
      if (w && a == 5) clr = d & 7;
      m_stat = (m_stat & ~clr) | set;
      if (w && a == 0 && (d & 7) != 0) begin bh = 0; bv = 0; cur = live; end
      else if (!run) begin bh = 0; bv = 0; cur = live; end
      else if (hl) begin
         bh = 0;
         if (vl) begin bv = 0; cur = live; end
         else bv++;
      end else bh++;
      if (w) begin
         case (a)
            0: m_mode = d & 7;
            1: begin live[4] = (d >> 22) & 1023; live[3] = (d >> 11) & 2047; live[2] = d & 2047; end
            2: begin live[7] = (d >> 22) & 1023; live[6] = (d >> 11) & 2047; live[5] = d & 2047; end
            3: begin live[1] = (d >> 16) & 2047; live[0] = d & 2047; end
            4: m_pol = d & 7;
            6: m_mask = d & 63;
            7: m_lc = d & 2047;
            default: if (a >= 8 && a < 16) bar_c[a-8] = d & 32'h00FF_FFFF;
         endcase
      end
   endtask

   task automatic step(bit w, int a, int d);
      reg_wr = w; reg_addr = AW'(a); reg_wdata = d;
      @(posedge clk);
      model_edge(w, a, d);
      @(negedge clk);
      reg_wr = 1'b0;
      pix_in = pix_in + 24'h135791;
      #1 check_outputs();
   endtask

   task automatic wr(int a, int d); step(1'b1, a, d); endtask
   task automatic run_n(int n); repeat (n) step(1'b0, 0, 0); endtask

   task automatic rd(string r, int a, int exp);
      reg_addr = AW'(a);
      #1 check(r, "readback", int'(reg_rdata), exp);
   endtask

   initial begin
      foreach (live[i]) begin live[i] = 0; cur[i] = 0; bar_c[i] = 0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      req = "R1";
      #1 check_outputs();
      rd("R1", 6, 63);
      rd("R1", 0, 0);
      rd("R1", 5, 0);

      // R3 layout and readback
      req = "R3";
      wr(1, (1 << 22) | (3 << 11) | 2);
      wr(2, (1 << 22) | (2 << 11) | 1);
      wr(3, (4 << 16) | 16);
      rd("R3", 1, (1 << 22) | (3 << 11) | 2);
      rd("R3", 2, (1 << 22) | (2 << 11) | 1);
      rd("R3", 3, (4 << 16) | 16);
      for (int i = 0; i < 8; i++)
         wr(8 + i, ((16 * i + 1) << 16) | ((255 - 3 * i) << 8) | (7 * i));
      rd("R7", 11, (49 << 16) | (246 << 8) | 21);
      wr(7, 2);
      wr(6, 0);

      // R6 pass-through, R8 start from origin, R2 ordering
      req = "R6";
      wr(0, 1);
      run_n(2 * 176 + 10);

      // R10 status readback and write-one-to-clear
      req = "R10";
      rd("R10", 5, m_stat);
      wr(5, m_stat);
      rd("R10", 5, m_stat);
      run_n(100);
      rd("R10", 5, m_stat);

      // R5 polarity
      req = "R5";
      wr(4, 7); run_n(180);
      wr(4, 2); run_n(60);
      wr(4, 0);

      // R7 bars, width divisible by 8
      req = "R7";
      wr(0, 4); run_n(180);

      // R6 other mode codes are off
      req = "R6";
      wr(0, 2); run_n(20);
      wr(0, 3); run_n(20);
      wr(0, 0); run_n(5);

      // R9 geometry change mid-frame takes effect at frame wrap
      req = "R9";
      wr(0, 1); run_n(60);
      wr(1, (1 << 22) | (3 << 11) | 4);
      wr(3, (4 << 16) | 20);
      run_n(400);

      // R7 remainder to last bar, then narrow width
      req = "R7";
      wr(0, 4); run_n(230);
      wr(3, (4 << 16) | 5); run_n(300);

      // R8 restart mid-frame
      req = "R8";
      wr(3, (4 << 16) | 16);
      wr(0, 1); run_n(33);
      wr(0, 1); run_n(40);
      wr(0, 4); run_n(20);

      // R11 masking
      req = "R11";
      wr(6, 63); run_n(200);
      rd("R11", 6, 63);
      wr(6, 5); run_n(200);
      wr(5, 7); run_n(60);
      wr(6, 0); run_n(200);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_500_000;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule